// File: doc/BRIEF.md
# I2C Byte-Level Master Bit Engine

This block is the physical layer of an I2C master. A sequencer hands it one operation at a time: a START, a STOP, a byte write or a byte read. The block then produces the matching cycles on the two open-drain bus lines. It only ever pulls a line low or lets it go. When the operation ends it pulses a done strobe. A write returns the acknowledge bit the target drove. A read returns the byte it received, and the block drives the acknowledge bit the sequencer asked for.

Bus timing comes from a 16-bit divider programmed in core clock cycles. SCL feedback passes through a synchronizer and a glitch filter of selectable length. The high phase is only counted once that filtered feedback reads high, so a target can stretch the clock by holding SCL low. SDA is moved a programmable number of cycles after each SCL falling edge. This keeps data changes clear of the clock edge.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is held, and right after it is released, both pull-low outputs are 0, `opReady` is 1 and `opDone` is 0.
- R2: Inside a byte, SCL is pulled low for max(divider+1, filterSel+4) cycles between the falling edge and the release that starts the next bit. The second term covers the time the filtered feedback needs to see the line low.
- R3: During a byte, SCL reads high on the bus for exactly divider+filterSel+5 cycles. The count starts when the line really goes high, after any stretch by the target. The extra cycles are the 2-stage synchronizer, the filterSel+1 filter samples and 2 cycles of registers.
- R4: Inside a byte, a change of `sdaPullLow` comes exactly e+1 cycles after SCL is pulled low, where e = min(sdaDelay, divider-1). The divider must be at least 1.
- R5: A write (opCode 2) puts `opData` on SDA MSB first. SDA is released in the ninth bit, and the SDA level seen on the ninth high phase is returned on `rxAck` (0 means acknowledged).
- R6: A read (opCode 3) shifts the SDA level of eight high phases into `rxData`, MSB first. In the ninth bit SDA is pulled low when `opNack` is 0 and released when it is 1.
- R7: A START (opCode 0) pulls SDA low while SCL is high. This works from an idle bus and also as a repeated start. It finishes with both lines pulled low.
- R8: A STOP (opCode 1) releases SDA while SCL is high and finishes with both lines released.
- R9: `opDone` is a one-cycle pulse per operation. `opReady` is low from acceptance until done. An `opValid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request, taken when `opReady` is 1 |
| opCode | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| opData | input | 8 | Byte to write |
| opNack | input | 1 | For reads: 1 releases SDA in the acknowledge bit |
| divider | input | 16 | SCL phase length minus one, in core cycles |
| sdaDelay | input | 8 | Cycles from SCL falling to the SDA update |
| filterSel | input | 2 | SCL glitch filter length minus one |
| sclIn | input | 1 | SCL level read back from the bus |
| sdaIn | input | 1 | SDA level read back from the bus |
| opReady | output | 1 | Engine idle, able to take an operation |
| opDone | output | 1 | One-cycle completion pulse |
| rxData | output | 8 | Last byte read |
| rxAck | output | 1 | SDA level sampled in the ninth bit |
| sclPullLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong phase counter or filter state shows up on the very next SCL high or low period as a duration that is off by whole cycles. The bench therefore times every period of every byte against the arithmetic formulas over a sweep of divider, delay and filter settings, with random clock stretching. A corrupted shift register or bit counter shows up at the end of the same operation, as a wrong byte seen by the modelled target, a wrong `rxData` or a misplaced acknowledge. A state machine that takes the wrong branch shows up within one operation as a spurious or missing START or STOP edge on the bus.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;    // restart the phase counter
    logic load;      // latch a new operation
    logic sclDrive;  // pull SCL low
    logic sclFree;   // release SCL
    logic sdaLow;    // pull SDA low (start / stop framing)
    logic sdaFree;   // release SDA (start / stop framing)
    logic sdaBit;    // put the current data or acknowledge bit on SDA
    logic sample;    // capture SDA at the end of a high phase
    logic nextSlot;  // advance to the next bit
  } strobe_t;

endpackage

// File: rtl/i2cbe_line_sync.sv
module i2cbe_line_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [FILT_W-1:0] filterSel,
  output logic              sclHigh,
  output logic              sdaLevel
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclIn;
          sdaSync[g] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else begin
          sclSync[g] <= sclSync[g-1];
          sdaSync[g] <= sdaSync[g-1];
        end
      end
    end
  end

  logic              sclRaw;
  logic              sclFilt;
  logic [FILT_W-1:0] glitchCnt;

  assign sclRaw = sclSync[SYNC_STAGES-1];

  // the filtered level follows only after filterSel+1 agreeing samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclFilt   <= 1'b1;
      glitchCnt <= '0;
    end else if (sclRaw != sclFilt) begin
      if (glitchCnt == filterSel) begin
        sclFilt   <= sclRaw;
        glitchCnt <= '0;
      end else begin
        glitchCnt <= glitchCnt + 1'b1;
      end
    end else begin
      glitchCnt <= '0;
    end
  end

  assign sclHigh  = sclFilt;
  assign sdaLevel = sdaSync[SYNC_STAGES-1];

  p_filter_follows_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclFilt) |-> ($past(sclRaw) == sclFilt));

  p_glitch_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    glitchCnt <= filterSel);

endmodule

// File: rtl/i2cbe_datapath.sv
module i2cbe_datapath
  import i2cbe_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DLY_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  op_e               opCode,
  input  logic [BYTE_W-1:0] opData,
  input  logic              opNack,
  input  logic [DIV_W-1:0]  divider,
  input  logic [DLY_W-1:0]  sdaDelay,
  input  logic              sdaLevel,
  output op_e               curOp,
  output logic              cntEnd,
  output logic              delayHit,
  output logic              lastSlot,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxAck
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [DIV_W-1:0]  phaseCnt;
  logic [DIV_W-1:0]  dlyExt;
  logic [DIV_W-1:0]  delayEff;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              nackQ;

  assign dlyExt   = DIV_W'(sdaDelay);
  assign delayEff = (dlyExt >= divider) ? divider - 1'b1 : dlyExt;
  assign cntEnd   = (phaseCnt >= divider);
  assign delayHit = (phaseCnt == delayEff);
  assign lastSlot = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (!rstN) phaseCnt <= '0;
    else if (strb.cntClr) phaseCnt <= '0;
    else phaseCnt <= phaseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOp    <= OP_START;
      shiftReg <= '0;
      bitCnt   <= '0;
      nackQ    <= 1'b0;
      rxData   <= '0;
      rxAck    <= 1'b1;
    end else if (strb.load) begin
      curOp    <= opCode;
      shiftReg <= opData;
      nackQ    <= opNack;
      bitCnt   <= '0;
    end else begin
      if (strb.sample) begin
        if (lastSlot) begin
          rxAck <= sdaLevel;
        end else if (curOp == OP_READ) begin
          shiftReg <= {shiftReg[BYTE_W-2:0], sdaLevel};
          if (bitCnt == CNT_W'(BYTE_W - 1)) rxData <= {shiftReg[BYTE_W-2:0], sdaLevel};
        end
      end
      if (strb.nextSlot) begin
        bitCnt <= bitCnt + 1'b1;
        if (curOp == OP_WRITE) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      if (strb.sclDrive) sclPullLow <= 1'b1;
      else if (strb.sclFree) sclPullLow <= 1'b0;

      if (strb.sdaLow) sdaPullLow <= 1'b1;
      else if (strb.sdaFree) sdaPullLow <= 1'b0;
      else if (strb.sdaBit) begin
        if (lastSlot) sdaPullLow <= (curOp == OP_READ) ? !nackQ : 1'b0;
        else sdaPullLow <= (curOp == OP_WRITE) ? !shiftReg[BYTE_W-1] : 1'b0;
      end
    end
  end

  // SDA may move under a released SCL only to frame a start or a stop
  p_sda_framing_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!sclPullLow && !$past(sclPullLow) && !$stable(sdaPullLow))
      |-> (curOp == OP_START || curOp == OP_STOP));

  p_bit_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/i2cbe_ctrl.sv
module i2cbe_ctrl
  import i2cbe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  op_e     opCode,
  input  op_e     curOp,
  input  logic    cntEnd,
  input  logic    delayHit,
  input  logic    lastSlot,
  input  logic    sclHigh,
  input  logic    sclPullLow,
  output strobe_t strb,
  output logic    opReady,
  output logic    opDone
);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_RISE, S_HIGH, S_HOLD} state_e;

  state_e state, nextState;
  logic   doneNext;

  always_comb begin
    strb      = '0;
    nextState = state;
    doneNext  = 1'b0;
    case (state)
      S_IDLE: if (opValid) begin
        strb.load   = 1'b1;
        strb.cntClr = 1'b1;
        nextState   = (opCode == OP_START && !sclPullLow) ? S_RISE : S_LOW;
      end
      S_LOW: begin
        if (delayHit) begin
          case (curOp)
            OP_START: strb.sdaFree = 1'b1;
            OP_STOP:  strb.sdaLow  = 1'b1;
            default:  strb.sdaBit  = 1'b1;
          endcase
        end
        // release only once the feedback has confirmed the line is low
        if (cntEnd && !sclHigh) begin
          strb.sclFree = 1'b1;
          nextState    = S_RISE;
        end
      end
      S_RISE: if (sclHigh) begin
        strb.cntClr = 1'b1;
        nextState   = S_HIGH;
      end
      S_HIGH: if (cntEnd) begin
        strb.cntClr = 1'b1;
        case (curOp)
          OP_START: begin strb.sdaLow  = 1'b1; nextState = S_HOLD; end
          OP_STOP:  begin strb.sdaFree = 1'b1; nextState = S_HOLD; end
          default: begin
            strb.sample   = 1'b1;
            strb.sclDrive = 1'b1;
            if (lastSlot) begin
              doneNext  = 1'b1;
              nextState = S_IDLE;
            end else begin
              strb.nextSlot = 1'b1;
              nextState     = S_LOW;
            end
          end
        endcase
      end
      S_HOLD: if (cntEnd) begin
        doneNext  = 1'b1;
        nextState = S_IDLE;
        if (curOp == OP_START) strb.sclDrive = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opDone <= 1'b0;
    end else begin
      state  <= nextState;
      opDone <= doneNext;
    end
  end

  assign opReady = (state == S_IDLE);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  p_high_after_feedback_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HIGH && $past(state) == S_RISE) |-> $past(sclHigh));

  p_release_from_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclPullLow) |-> ($past(state) == S_LOW));

  p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> opReady);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cbe_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DLY_W       = 8,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [BYTE_W-1:0] opData,
  input  logic              opNack,
  input  logic [DIV_W-1:0]  divider,
  input  logic [DLY_W-1:0]  sdaDelay,
  input  logic [FILT_W-1:0] filterSel,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              opReady,
  output logic              opDone,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxAck,
  output logic              sclPullLow,
  output logic              sdaPullLow
);

  strobe_t strb;
  op_e     curOp;
  op_e     opKind;
  logic    cntEnd, delayHit, lastSlot, sclHigh, sdaLevel;

  assign opKind = op_e'(opCode);

  i2cbe_line_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .filterSel(filterSel), .sclHigh(sclHigh), .sdaLevel(sdaLevel)
  );

  i2cbe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opKind), .curOp(curOp),
    .cntEnd(cntEnd), .delayHit(delayHit), .lastSlot(lastSlot), .sclHigh(sclHigh),
    .sclPullLow(sclPullLow), .strb(strb), .opReady(opReady), .opDone(opDone)
  );

  i2cbe_datapath #(.DIV_W(DIV_W), .DLY_W(DLY_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opCode(opKind), .opData(opData),
    .opNack(opNack), .divider(divider), .sdaDelay(sdaDelay), .sdaLevel(sdaLevel),
    .curOp(curOp), .cntEnd(cntEnd), .delayHit(delayHit), .lastSlot(lastSlot),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .rxData(rxData), .rxAck(rxAck)
  );

endmodule

// File: tb/i2c_bit_engine_bench.sv
module i2c_bit_engine_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, opValid, opNack;
  logic [1:0]  opCode;
  logic [7:0]  opData;
  logic [15:0] divider;
  logic [7:0]  sdaDelay;
  logic [1:0]  filterSel;
  logic        opReady, opDone, rxAck, sclPullLow, sdaPullLow;
  logic [7:0]  rxData;
  logic        holdScl = 1'b0;
  logic        slvPullSda = 1'b0;
  logic        sclIn, sdaIn;

  assign sclIn = !sclPullLow && !holdScl;
  assign sdaIn = !sdaPullLow && !slvPullSda;

  i2c_bit_engine u_i2c_bit_engine (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opData(opData),
    .opNack(opNack), .divider(divider), .sdaDelay(sdaDelay), .filterSel(filterSel),
    .sclIn(sclIn), .sdaIn(sdaIn), .opReady(opReady), .opDone(opDone),
    .rxData(rxData), .rxAck(rxAck), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  int checks = 0, errors = 0, monChecks = 0, monErrors = 0;
  int opTag = 0, slvModeReq = 0;
  logic inData = 1'b0, stretchEn = 1'b0, ackOn = 1'b1;
  logic [7:0] txByte = 8'h00;

  // target model and bus monitor
  logic [7:0] slvByte = 8'h00;
  logic ackSeen = 1'b1;
  int startCnt = 0, stopCnt = 0;
  int cyc = 0, seenTag = 0, slvMode = 0, riseCnt = 0, pinFalls = 0, stretchLeft = 0;
  int riseT = 0, fallT = 0, expV = 0;
  logic busScl, busSda, prevBusScl = 1'b1, prevBusSda = 1'b1;
  logic prevPin = 1'b0, prevPinSda = 1'b0, prevDone = 1'b0;

  task automatic monCheck(string tag, int act, int exp);
    monChecks++;
    if (act != exp) begin
      monErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      holdScl = 1'b0; slvPullSda = 1'b0; stretchLeft = 0;
      prevBusScl = 1'b1; prevBusSda = 1'b1; prevPin = 1'b0; prevPinSda = 1'b0; prevDone = 1'b0;
    end else begin
      cyc++;
      if (opTag != seenTag) begin
        seenTag = opTag; slvMode = slvModeReq; riseCnt = 0; pinFalls = 0;
      end
      if (sclPullLow && !prevPin) stretchLeft = stretchEn ? int'($urandom_range(1, 6)) : 0;
      else if (!sclPullLow && stretchLeft > 0) stretchLeft--;
      holdScl = (stretchLeft != 0);
      busScl = !sclPullLow && !holdScl;
      if (!busScl)
        slvPullSda = (slvMode == 2 && riseCnt < 8) ? !txByte[7-riseCnt]
                   : (slvMode == 1 && riseCnt == 8 && ackOn);
      busSda = !sdaPullLow && !slvPullSda;
      if (busScl && prevBusScl) begin
        if (prevBusSda && !busSda) startCnt++;
        if (!prevBusSda && busSda) stopCnt++;
      end
      if (busScl && !prevBusScl) begin
        riseT = cyc;
        if (riseCnt < 8) slvByte = {slvByte[6:0], busSda};
        else if (riseCnt == 8) ackSeen = busSda;
        riseCnt++;
      end
      if (!busScl && prevBusScl && inData)
        monCheck("R3 SCL high time after release", cyc - riseT, int'(divider) + int'(filterSel) + 5);
      if (sclPullLow && !prevPin) begin fallT = cyc; pinFalls++; end
      if (!sclPullLow && prevPin && inData && pinFalls > 0) begin
        expV = (int'(divider) + 1 > int'(filterSel) + 4) ? int'(divider) + 1 : int'(filterSel) + 4;
        monCheck("R2 SCL low time", cyc - fallT, expV);
      end
      if (inData && sclPullLow && pinFalls > 0 && sdaPullLow != prevPinSda) begin
        expV = (int'(sdaDelay) >= int'(divider)) ? int'(divider) - 1 : int'(sdaDelay);
        monCheck("R4 SDA change delay", cyc - fallT, expV + 1);
      end
      if (opDone && prevDone) monCheck("R9 done pulse width", 2, 1);
      prevBusScl = busScl; prevBusSda = busSda; prevPin = sclPullLow;
      prevPinSda = sdaPullLow; prevDone = opDone;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] code, input logic [7:0] data, input logic nack,
                       input int mode, input bit busyPoke);
    while (!opReady) @(negedge clk);
    slvModeReq = mode;
    inData = (code >= 2'd2);
    opTag++;
    @(negedge clk);
    opValid = 1'b1; opCode = code; opData = data; opNack = nack;
    @(negedge clk);
    opValid = 1'b0;
    checkEq("R9 ready low while busy", int'(opReady), 0);
    if (busyPoke) begin
      repeat (3) @(negedge clk);
      opValid = 1'b1; opCode = 2'd1;
      @(negedge clk);
      opValid = 1'b0;
    end
    while (!opDone) @(negedge clk);
    @(negedge clk);
    inData = 1'b0;
    checkEq("R9 ready after done", int'(opReady), 1);
  endtask

  task automatic report(int extraErr);
    $display("Simulation finished: %0d checks, %0d errors", checks + monChecks,
             errors + monErrors + extraErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R9 watchdog: actual hung expected completion");
    report(1);
    $finish;
  end

  initial begin
    int idx = 0;
    int s0, p0;
    rstN = 1'b0; opValid = 1'b0; opCode = 2'd0; opData = 8'h00; opNack = 1'b0;
    divider = 16'd2; sdaDelay = 8'd0; filterSel = 2'd0;
    repeat (4) @(negedge clk);
    checkEq("R1 reset scl", int'(sclPullLow), 0);
    checkEq("R1 reset sda", int'(sdaPullLow), 0);
    checkEq("R1 reset ready", int'(opReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 after reset done", int'(opDone), 0);
    checkEq("R1 after reset scl", int'(sclPullLow), 0);
    for (int di = 0; di < 2; di++) begin
      for (int f = 0; f < 4; f++) begin
        for (int ds = 0; ds < 3; ds++) begin
          logic [7:0] wd;
          divider   = (di == 0) ? 16'd2 : 16'd5;
          sdaDelay  = (ds == 0) ? 8'd0 : (ds == 1) ? 8'd1 : 8'(divider + 3);
          filterSel = 2'(f);
          stretchEn = idx[0];
          ackOn     = !idx[1];
          wd        = 8'hA5 ^ 8'(idx * 37);
          txByte    = 8'(idx * 53 + 1);
          s0 = startCnt; p0 = stopCnt;
          runOp(2'd0, 8'h00, 1'b0, 0, 1'b0);
          checkEq("R7 start edge seen", startCnt, s0 + 1);
          checkEq("R7 start leaves scl low", int'(sclPullLow), 1);
          checkEq("R7 start leaves sda low", int'(sdaPullLow), 1);
          runOp(2'd2, wd, 1'b0, 1, (idx % 4) == 0);
          checkEq("R5 target got byte MSB first", int'(slvByte), int'(wd));
          checkEq("R5 ack returned", int'(rxAck), int'(!ackOn));
          checkEq("R9 busy request ignored", stopCnt, p0);
          checkEq("R9 scl still held after write", int'(sclPullLow), 1);
          runOp(2'd0, 8'h00, 1'b0, 0, 1'b0);
          checkEq("R7 repeated start seen", startCnt, s0 + 2);
          runOp(2'd3, 8'h00, idx[2], 2, 1'b0);
          checkEq("R6 read byte", int'(rxData), int'(txByte));
          checkEq("R6 ack driven", int'(ackSeen), int'(idx[2]));
          runOp(2'd1, 8'h00, 1'b0, 0, 1'b0);
          checkEq("R8 stop edge seen", stopCnt, p0 + 1);
          checkEq("R8 stop frees scl", int'(sclPullLow), 0);
          checkEq("R8 stop frees sda", int'(sdaPullLow), 0);
          checkEq("R7 no extra start", startCnt, s0 + 2);
          idx++;
        end
      end
    end
    repeat (4) @(negedge clk);
    report(0);
    $finish;
  end

endmodule